// File: doc/BRIEF.md
# Wraparound Instruction Extractor

This block sits between a circular instruction fetch buffer and the per-wavefront instruction queue. Each cycle it looks at the bytes waiting at its read pointer and pulls out up to two variable-length instructions, 32 or 64 bits each, in program order. It pushes them into the queue, each one tagged with a running sequence number. It keeps its own word-aligned read pointer into the buffer. It reports how many bytes it used up in the cycle, so the buffer can lower its count of unread bytes.

The length of each instruction comes from one marker bit in its low word. This small length decode stands in for a full decoder. An instruction can start in the last 32-bit word of the buffer. In that case the block takes the low half from that last word and the high half from the first word, then moves the pointer to a position just past the start. A lane extracts only when the queue has room for it and at least a full 64-bit window of bytes lies ahead of it. Near the end of a stream or with a full queue, extraction therefore stalls rather than reading past valid data.

Top module: `ie_extract`

## Requirements
- R1: While reset is held, and in the first cycle after it with no bytes available, no lane pushes and the byte read pointer is 0. The first instruction pushed after reset carries sequence number 0.
- R2: Bit 0 of an instruction's first 32-bit word gives its length: 1 means 8 bytes, 0 means 4 bytes. A long instruction is presented as {following word, first word}. A short one is {32'h0, first word}. `push_long` shows the decoded length.
- R3: Lane i (i = 0, 1) pushes only if `q_count` + i < QMAX and the bytes left after the lower lanes' instructions are at least 8. With `avail_bytes` below 8, or with the queue full, nothing is pushed.
- R4: At most two instructions are pushed per cycle, and lane 1 pushes only when lane 0 pushes in the same cycle.
- R5: When an instruction starts at the buffer's last word (pointer + 8 > buffer size), its low word is the last buffer word and its high word is buffer word 0. The pointer then becomes the instruction length minus 4.
- R6: The read pointer advances by the total length extracted, modulo the buffer size. It wraps to 0 when it lands exactly on the buffer end and never points past it.
- R7: Pushed instructions carry consecutive sequence numbers (modulo 2^SEQ_W), with lane 0 taking the lower number.
- R8: `consumed` equals the sum of the byte lengths of the instructions pushed in the same cycle.
- R9: Instructions leave in stream order, including across any number of buffer wraps, and none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_data | input | BUF_BYTES*8 | Buffer contents; 32-bit word w sits at bits [32w+31:32w] |
| avail_bytes | input | $clog2(BUF_BYTES+1) | Unread bytes starting at the read pointer |
| q_count | input | $clog2(QMAX+1) | Current occupancy of the instruction queue |
| rd_ptr | output | $clog2(BUF_BYTES/4)+2 | Byte read pointer (always a multiple of 4) |
| push_valid | output | LANES | Lane pushes an instruction this cycle |
| push_inst | output | LANES*64 | Instruction per lane, lane l at [64l+63:64l] |
| push_long | output | LANES | Lane's instruction is 8 bytes long |
| push_seq | output | LANES*SEQ_W | Sequence number per lane |
| consumed | output | $clog2(BUF_BYTES+1) | Bytes taken from the buffer this cycle |

## Verification
The push outputs and `consumed` depend combinationally on the inputs and on the registered pointer and sequence count. They belong to the same cycle as the inputs that produced them. The pointer and sequence base move at the next rising edge. The bench therefore drives `q_count`, `avail_bytes` and `buf_data` on the falling edge, samples all outputs 1 ns later, and then accounts for the pushes itself. It expects `rd_ptr` in the next sampled cycle to equal its own running byte total modulo the buffer size. Queue occupancy and unread-byte counts are updated in the bench from the instructions it expected, never from the design's own reports.

// File: rtl/ie_pkg.sv
package ie_pkg;

  localparam int IE_WORD_BYTES = 4;
  localparam int IE_WIN_BYTES  = 8;

  // Byte length of an instruction, from the marker bit of its first word.
  function automatic int ie_len_bytes(input logic [31:0] lo);
    return lo[0] ? IE_WIN_BYTES : IE_WORD_BYTES;
  endfunction

  // Word index after stepping forward, folded back into the ring.
  function automatic int ie_wrap_add(input int p, input int step, input int words);
    int s;
    s = p + step;
    return (s >= words) ? s - words : s;
  endfunction

  // A full window read starting at word p would run off the buffer end.
  function automatic logic ie_needs_split(input int p, input int buf_bytes);
    return (p * IE_WORD_BYTES + IE_WIN_BYTES) > buf_bytes;
  endfunction

endpackage

// File: rtl/ie_lane.sv
module ie_lane
  import ie_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int QMAX      = 4,
  parameter int LANE      = 0,
  localparam int WORDS    = BUF_BYTES / IE_WORD_BYTES,
  localparam int WPW      = $clog2(WORDS),
  localparam int AVW      = $clog2(BUF_BYTES + 1),
  localparam int QW       = $clog2(QMAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BUF_BYTES*8-1:0] buf_data,
  input  logic [WPW-1:0]         ptr_in,
  input  logic [AVW-1:0]         avail_in,
  input  logic [QW-1:0]          q_count,
  input  logic                   chain_ok,
  output logic                   take,
  output logic [63:0]            inst,
  output logic                   is_long,
  output logic                   split,
  output logic [WPW-1:0]         ptr_out,
  output logic [AVW-1:0]         avail_out,
  output logic [AVW-1:0]         used
);

  logic [WPW-1:0] hi_idx;
  logic [31:0]    lo_word;
  logic [31:0]    hi_word;
  logic           room_ok;
  logic           bytes_ok;
  logic           at_tail;
  int             step_words;

  always_comb begin
    hi_idx     = WPW'(ie_wrap_add(32'(ptr_in), 1, WORDS));
    lo_word    = buf_data[32'(ptr_in) * 32 +: 32];
    hi_word    = buf_data[32'(hi_idx) * 32 +: 32];
    is_long    = (ie_len_bytes(lo_word) == IE_WIN_BYTES);
    step_words = is_long ? 2 : 1;
    room_ok    = (32'(q_count) + LANE) < QMAX;
    bytes_ok   = avail_in >= AVW'(IE_WIN_BYTES);
    take       = chain_ok && room_ok && bytes_ok;
    at_tail    = ie_needs_split(32'(ptr_in), BUF_BYTES);
    split      = take && at_tail;
    inst       = is_long ? {hi_word, lo_word} : {32'h0, lo_word};
    if (!take) begin
      used    = '0;
      ptr_out = ptr_in;
    end else if (at_tail) begin
      // straddling word: resume just past the ring start
      used    = AVW'(ie_len_bytes(lo_word));
      ptr_out = WPW'(step_words - 1);
    end else begin
      used    = AVW'(ie_len_bytes(lo_word));
      ptr_out = WPW'(ie_wrap_add(32'(ptr_in), step_words, WORDS));
    end
    avail_out = avail_in - used;
  end

  assert_window_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (avail_in >= AVW'(IE_WIN_BYTES)));

  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !split) |-> ((32'(ptr_in) + step_words) <= WORDS));

  assert_tail_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    split |-> (32'(ptr_out) == step_words - 1));

endmodule

// File: rtl/ie_tag_ctr.sv
module ie_tag_ctr #(
  parameter int LANES = 2,
  parameter int SEQ_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       take,
  output logic [LANES*SEQ_W-1:0] tags
);

  logic [SEQ_W-1:0] base_q;
  logic [SEQ_W-1:0] n_take;

  assign n_take = SEQ_W'($countones(take));

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_q + n_take;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_tag
    assign tags[i*SEQ_W +: SEQ_W] = base_q + SEQ_W'(i);
  end

  assert_seq_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tags[SEQ_W-1:0] == $past(tags[SEQ_W-1:0]) + SEQ_W'($countones($past(take)))));

endmodule

// File: rtl/ie_extract.sv
module ie_extract
  import ie_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int QMAX      = 4,
  parameter int LANES     = 2,
  parameter int SEQ_W     = 8,
  localparam int WORDS    = BUF_BYTES / IE_WORD_BYTES,
  localparam int WPW      = $clog2(WORDS),
  localparam int AVW      = $clog2(BUF_BYTES + 1),
  localparam int QW       = $clog2(QMAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BUF_BYTES*8-1:0] buf_data,
  input  logic [AVW-1:0]         avail_bytes,
  input  logic [QW-1:0]          q_count,
  output logic [WPW+1:0]         rd_ptr,
  output logic [LANES-1:0]       push_valid,
  output logic [LANES*64-1:0]    push_inst,
  output logic [LANES-1:0]       push_long,
  output logic [LANES*SEQ_W-1:0] push_seq,
  output logic [AVW-1:0]         consumed
);

  logic [WPW-1:0] wptr_q;
  logic [WPW-1:0] ptr_c   [LANES+1];
  logic [AVW-1:0] avail_c [LANES+1];
  logic           ok_c    [LANES+1];
  logic [LANES-1:0] split_w;
  logic [AVW-1:0]   used_w [LANES];

  assign ptr_c[0]   = wptr_q;
  assign avail_c[0] = avail_bytes;
  assign ok_c[0]    = 1'b1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ie_lane #(.BUF_BYTES(BUF_BYTES), .QMAX(QMAX), .LANE(l)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .buf_data (buf_data),
      .ptr_in   (ptr_c[l]),
      .avail_in (avail_c[l]),
      .q_count  (q_count),
      .chain_ok (ok_c[l]),
      .take     (push_valid[l]),
      .inst     (push_inst[l*64 +: 64]),
      .is_long  (push_long[l]),
      .split    (split_w[l]),
      .ptr_out  (ptr_c[l+1]),
      .avail_out(avail_c[l+1]),
      .used     (used_w[l])
    );
    assign ok_c[l+1] = push_valid[l];
  end

  ie_tag_ctr #(.LANES(LANES), .SEQ_W(SEQ_W)) u_tags (
    .clk  (clk),
    .rst_n(rst_n),
    .take (push_valid),
    .tags (push_seq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= ptr_c[LANES];
  end

  assign rd_ptr   = {wptr_q, 2'b00};
  assign consumed = avail_bytes - avail_c[LANES];

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (32'(rd_ptr) == (32'($past(rd_ptr)) + 32'($past(consumed))) % BUF_BYTES));

  assert_queue_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(push_valid) + 32'(q_count)) <= QMAX);

  assert_used_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid == '0) |-> (consumed == '0));

  assert_tail_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (split_w[0] && $countones(push_valid) == 1) |=> (rd_ptr == ($past(push_long[0]) ? 5'd4 : 5'd0)));

  if (LANES > 1) begin : g_order
    assert_lane_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid[1] |-> push_valid[0]);
  end

endmodule

// File: tb/sim_ie_extract.sv
module sim_ie_extract;

  localparam int BUF  = 32;
  localparam int QMAX = 4;
  localparam int W    = BUF / 4;
  localparam int N    = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [BUF*8-1:0] buf_data;
  logic [5:0]      avail_bytes;
  logic [2:0]      q_count;
  logic [4:0]      rd_ptr;
  logic [1:0]      push_valid;
  logic [127:0]    push_inst;
  logic [1:0]      push_long;
  logic [15:0]     push_seq;
  logic [5:0]      consumed;

  ie_extract #(.BUF_BYTES(BUF), .QMAX(QMAX), .LANES(2), .SEQ_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .buf_data(buf_data), .avail_bytes(avail_bytes),
    .q_count(q_count), .rd_ptr(rd_ptr), .push_valid(push_valid),
    .push_inst(push_inst), .push_long(push_long), .push_seq(push_seq),
    .consumed(consumed)
  );

  logic [31:0] stream [N+2];
  logic [31:0] mem    [W];
  logic [63:0] exp_inst  [$];
  bit          exp_long  [$];
  bit          exp_split [$];

  int checks = 0, fails = 0;
  int qc = 0, av = 0, fed = 0, total = 0, exp_seq = 0, cyc = 0;
  int fill_rate = 1;
  bit pop_en = 1'b1;
  bit hung = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Stream: long whenever a start lands on a word 7 mod 16, short on 15 mod 16.
  task automatic gen_stream();
    int j = 0, i = 0;
    bit lng;
    while (j < N - 2) begin
      lng = ((j % 16) == 7) || (((j % 16) != 15) && ((i % 3) == 1));
      if (lng && (j + 1 < N - 2)) begin
        stream[j]   = {i[15:0], 8'hC3, j[6:0], 1'b1};
        stream[j+1] = {16'hBEEF ^ i[15:0], j[15:0]};
        j += 2;
      end else begin
        stream[j] = {i[15:0], 8'h5A, j[6:0], 1'b0};
        j += 1;
      end
      i++;
    end
    stream[N-2] = 32'h7000_0010;
    stream[N-1] = 32'h7100_0020;
    stream[N]   = 32'h0000_1230;
    stream[N+1] = 32'h0000_4560;
  endtask

  // Driver: parse the stream on its own terms and queue the expected items.
  task automatic build_expected();
    int k = 0;
    while (k <= N) begin
      if (stream[k][0]) begin
        exp_inst.push_back({stream[k+1], stream[k]});
        exp_long.push_back(1'b1);
        exp_split.push_back((k % W) == W - 1);
        k += 2;
      end else begin
        exp_inst.push_back({32'h0, stream[k]});
        exp_long.push_back(1'b0);
        exp_split.push_back((k % W) == W - 1);
        k += 1;
      end
    end
  endtask

  // One cycle: drive at the falling edge, monitor 1 ns later, then account.
  task automatic step();
    int n = 0, lens = 0;
    logic [63:0] ei;
    bit el, es;
    @(negedge clk);
    q_count     = 3'(qc);
    avail_bytes = 6'(av);
    for (int w = 0; w < W; w++) buf_data[w*32 +: 32] = mem[w];
    #1;
    cyc++;
    check(32'(rd_ptr) == total % BUF, "R6", "rd_ptr", rd_ptr, total % BUF);
    for (int l = 0; l < 2; l++) begin
      if (push_valid[l]) begin
        if (exp_inst.size() == 0) begin
          check(1'b0, "R9", "unexpected push", push_inst[l*64 +: 64], 0);
        end else begin
          ei = exp_inst.pop_front();
          el = exp_long.pop_front();
          es = exp_split.pop_front();
          check(push_inst[l*64 +: 64] == ei, es ? "R5" : "R2", "inst",
                push_inst[l*64 +: 64], ei);
          check(push_long[l] == el, "R2", "length", push_long[l], el);
          check(push_seq[l*8 +: 8] == 8'(exp_seq), "R7", "seq",
                push_seq[l*8 +: 8], exp_seq % 256);
          exp_seq++;
          n++;
          lens += el ? 8 : 4;
        end
      end
    end
    check(32'(consumed) == lens, "R8", "consumed", consumed, lens);
    check(qc + n <= QMAX, "R3", "queue room", qc + n, QMAX);
    if (av < 8) check(n == 0, "R3", "short window push", n, 0);
    if (push_valid[1]) check(push_valid[0], "R4", "lane order", push_valid, 3);
    total += lens;
    av    -= lens;
    qc    += n;
    if (pop_en && qc > 0) qc--;
    for (int f = 0; f < fill_rate; f++) begin
      if (av <= BUF - 4 && fed < N + 2) begin
        mem[fed % W] = stream[fed];
        fed++;
        av += 4;
      end
    end
    if (cyc > 20000) hung = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    buf_data = '0;
    avail_bytes = '0;
    q_count = '0;
    for (int w = 0; w < W; w++) mem[w] = '0;
    gen_stream();
    build_expected();
    repeat (3) @(negedge clk);
    #1;
    check(push_valid == 2'b00, "R1", "push in reset", push_valid, 0);
    check(rd_ptr == 5'd0, "R1", "rd_ptr in reset", rd_ptr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(push_valid == 2'b00 && rd_ptr == 5'd0, "R1", "idle after reset",
          {push_valid, rd_ptr}, 0);
    // slow fill: window often short
    fill_rate = 1; pop_en = 1'b1;
    repeat (60) if (!hung) step();
    // queue stalls: nothing drains
    fill_rate = 2; pop_en = 1'b0;
    repeat (20) if (!hung) step();
    check(qc == QMAX, "R3", "queue filled to limit", qc, QMAX);
    // drain the rest
    pop_en = 1'b1;
    while (!hung && (fed < N + 2 || exp_inst.size() != 0)) step();
    repeat (10) if (!hung) step();
    check(!hung, "R9", "watchdog", cyc, 20000);
    check(exp_inst.size() == 0, "R9", "items left", exp_inst.size(), 0);
    check(av == 4, "R3", "leftover bytes", av, 4);
    check(32'(rd_ptr) == (4 * (N + 1)) % BUF, "R6", "final rd_ptr", rd_ptr,
          (4 * (N + 1)) % BUF);
    check(push_valid == 2'b00, "R3", "no push with 4 bytes", push_valid, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule